// File: doc/BRIEF.md
# Dual-Channel Mapped Interrupt Controller

This block gathers a bank of external interrupt lines and presents them to a processor as two active-low request lines. One line serves a small fast group of logical interrupts and the other serves a larger normal group. Every logical interrupt owns a small control word. The word picks which external line feeds it, whether that line is read as a level or as an edge, which polarity counts as active, and whether the interrupt may raise a request.

External lines are first brought into the clock domain through two flops, then checked for edges. An edge-type logical interrupt remembers an event in a pending bit until software writes a 1 to that bit. A level-type logical interrupt shows the synchronized line directly. Each group exposes its pending bits and a status word that names the lowest-numbered interrupt that is both pending and enabled. Software uses the simple single-cycle register bus to program the control words, read pending and status, and clear edge events. The fast request takes priority at the processor. The two groups do not otherwise interact.

Top module: `irq_map_ctrl`

## Requirements
- R1: After reset both request outputs are high, every control word reads 0 and both pending registers read 0.
- R2: A bus write to address k (0 to 23) stores bits [6:0] of the write data as control word k, and a read of address k returns it zero-extended. Field layout: bit 0 enable, bit 1 edge mode (1) or level mode (0), bit 2 active-low (1) or active-high (0), bits [6:3] external line number.
- R3: A logical interrupt responds only to the external line selected by its bits [6:3]. Activity on any other line leaves it unchanged.
- R4: In active-high level mode the pending bit equals the external line, delayed two clock edges.
- R5: In active-low level mode the pending bit equals the inverse of the external line, delayed two clock edges.
- R6: In edge mode with active-high polarity, a rising edge on the selected line sets the pending bit at the third clock edge after the change. The bit stays set after the line returns low.
- R7: In edge mode with active-low polarity, only a falling edge sets the pending bit. A rising edge does not.
- R8: Writing 1 to a pending bit clears an edge-mode pending bit. Writing 0 has no effect. Writing 1 to a level-mode bit does not change it. A new edge in the same cycle as a clear leaves the bit set.
- R9: A disabled logical interrupt still records pending state, but it does not drive a request or appear in status.
- R10: The fast request (logical 0 to 3) and the normal request (logical 4 to 23) are each low exactly while at least one enabled, pending interrupt of their own group exists. Each is independent of the other group.
- R11: The status word of a group (fast at address 34, normal at address 35) has bit 31 set when the group has an active interrupt. Its low bits then give the lowest active index within the group. The word reads 0 when the group has no active interrupt.
- R12: Pending register bit j at address 32 belongs to logical j. Bit j at address 33 belongs to logical 4+j. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq | input | 16 | External interrupt lines, asynchronous |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Register address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| fast_req_n | output | 1 | Active-low request of the fast group |
| norm_req_n | output | 1 | Active-low request of the normal group |

## Verification
Suppose a pending flop is stuck, an edge detector uses the wrong polarity, or the source selector picks the wrong line. The pending register of the affected group shows the error at the third edge after the external change, and the group's request line shows it in the same cycle. A wrong priority order appears only in the status word, and only when two or more interrupts of one group are active together. For that reason the stimulus stacks several active sources in the normal group. A clear that is lost or misrouted remains visible in the pending register until the next write. The reference model therefore compares the readout and both request lines on every cycle, not only at the directed checkpoints.

// File: rtl/irq_map_pkg.sv
`timescale 1ns/1ps
package irq_map_pkg;
  // control word field positions
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_EDGE_BIT = 1;
  localparam int CTRL_LOW_BIT  = 2;
  localparam int CTRL_SRC_LSB  = 3;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int ctrl_width(input int src_w);
    return CTRL_SRC_LSB + src_w;
  endfunction
endpackage

// File: rtl/irq_in_sync.sv
`timescale 1ns/1ps
module irq_in_sync #(
  parameter int EXT_N = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXT_N-1:0] ext_i,
  output logic [EXT_N-1:0] lvl_o,
  output logic [EXT_N-1:0] rise_o,
  output logic [EXT_N-1:0] fall_o
);
  logic [EXT_N-1:0] meta_q;
  logic [EXT_N-1:0] sync_q;
  logic [EXT_N-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= ext_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign lvl_o  = sync_q;
  assign rise_o = sync_q & ~last_q;
  assign fall_o = ~sync_q & last_q;
endmodule

// File: rtl/irq_src.sv
`timescale 1ns/1ps
module irq_src import irq_map_pkg::*; #(
  parameter int EXT_N  = 16,
  parameter int SRC_W  = 4,
  parameter int CTRL_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [EXT_N-1:0]  lvl_i,
  input  logic [EXT_N-1:0]  rise_i,
  input  logic [EXT_N-1:0]  fall_i,
  input  logic              clr_i,
  output logic              view_o,
  output logic              active_o,
  output logic              hit_o,
  output logic              pend_o
);
  function automatic logic pick(input logic [EXT_N-1:0] v, input logic [SRC_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int k = 0; k < EXT_N; k++)
      if (s == SRC_W'(k)) r = v[k];
    return r;
  endfunction

  logic [SRC_W-1:0] src_sel;
  logic             en, edge_md, act_low;
  logic             sel_lvl;
  logic             pend_q;

  assign src_sel = ctrl_i[CTRL_SRC_LSB +: SRC_W];
  assign en      = ctrl_i[CTRL_EN_BIT];
  assign edge_md = ctrl_i[CTRL_EDGE_BIT];
  assign act_low = ctrl_i[CTRL_LOW_BIT];

  assign sel_lvl = pick(lvl_i, src_sel) ^ act_low;
  assign hit_o   = act_low ? pick(fall_i, src_sel) : pick(rise_i, src_sel);

  // a fresh edge wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (hit_o)  pend_q <= 1'b1;
    else if (clr_i)  pend_q <= 1'b0;
  end

  assign pend_o   = pend_q;
  assign view_o   = edge_md ? pend_q : sel_lvl;
  assign active_o = view_o & en;
endmodule

// File: rtl/irq_chan.sv
`timescale 1ns/1ps
module irq_chan #(
  parameter int SRC_N = 4,
  parameter int IDX_W = 2
) (
  input  logic [SRC_N-1:0] active_i,
  output logic             req_n_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  function automatic logic [IDX_W-1:0] lowest(input logic [SRC_N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = SRC_N - 1; k >= 0; k--)
      if (v[k]) r = IDX_W'(k);
    return r;
  endfunction

  assign valid_o = |active_i;
  assign idx_o   = lowest(active_i);
  assign req_n_o = ~valid_o;
endmodule

// File: rtl/irq_map_ctrl.sv
`timescale 1ns/1ps
module irq_map_ctrl import irq_map_pkg::*; #(
  parameter int EXT_N  = 16,
  parameter int FAST_N = 4,
  parameter int NORM_N = 20,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EXT_N-1:0]  ext_irq,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              fast_req_n,
  output logic              norm_req_n
);
  localparam int LOG_N  = FAST_N + NORM_N;
  localparam int SRC_W  = idx_width(EXT_N);
  localparam int CTRL_W = ctrl_width(SRC_W);
  localparam int FIDX_W = idx_width(FAST_N);
  localparam int NIDX_W = idx_width(NORM_N);
  localparam int A_BASE = 1 << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] A_PEND_F = ADDR_W'(A_BASE);
  localparam logic [ADDR_W-1:0] A_PEND_N = ADDR_W'(A_BASE + 1);
  localparam logic [ADDR_W-1:0] A_STAT_F = ADDR_W'(A_BASE + 2);
  localparam logic [ADDR_W-1:0] A_STAT_N = ADDR_W'(A_BASE + 3);

  logic [LOG_N-1:0][CTRL_W-1:0] ctrl_q;
  logic [EXT_N-1:0] sync_lvl, sync_rise, sync_fall;
  wire  [LOG_N-1:0] src_view, src_act, edge_hit, pend_q, clr_strb;
  logic             fast_valid, norm_valid;
  logic [FIDX_W-1:0] fast_idx;
  logic [NIDX_W-1:0] norm_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      for (int k = 0; k < LOG_N; k++)
        if (bus_wr && bus_addr == ADDR_W'(k))
          ctrl_q[k] <= bus_wdata[CTRL_W-1:0];
    end
  end

  irq_in_sync #(.EXT_N(EXT_N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ext_i  (ext_irq),
    .lvl_o  (sync_lvl),
    .rise_o (sync_rise),
    .fall_o (sync_fall)
  );

  for (genvar i = 0; i < LOG_N; i++) begin : g_src
    if (i < FAST_N) begin : g_fast_clr
      assign clr_strb[i] = bus_wr && (bus_addr == A_PEND_F) && bus_wdata[i];
    end else begin : g_norm_clr
      assign clr_strb[i] = bus_wr && (bus_addr == A_PEND_N) && bus_wdata[i-FAST_N];
    end

    irq_src #(.EXT_N(EXT_N), .SRC_W(SRC_W), .CTRL_W(CTRL_W)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_i   (ctrl_q[i]),
      .lvl_i    (sync_lvl),
      .rise_i   (sync_rise),
      .fall_i   (sync_fall),
      .clr_i    (clr_strb[i]),
      .view_o   (src_view[i]),
      .active_o (src_act[i]),
      .hit_o    (edge_hit[i]),
      .pend_o   (pend_q[i])
    );
  end

  irq_chan #(.SRC_N(FAST_N), .IDX_W(FIDX_W)) u_fast (
    .active_i (src_act[FAST_N-1:0]),
    .req_n_o  (fast_req_n),
    .valid_o  (fast_valid),
    .idx_o    (fast_idx)
  );

  irq_chan #(.SRC_N(NORM_N), .IDX_W(NIDX_W)) u_norm (
    .active_i (src_act[LOG_N-1:FAST_N]),
    .req_n_o  (norm_req_n),
    .valid_o  (norm_valid),
    .idx_o    (norm_idx)
  );

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < LOG_N; k++)
      if (bus_addr == ADDR_W'(k)) bus_rdata[CTRL_W-1:0] = ctrl_q[k];
    if (bus_addr == A_PEND_F) bus_rdata[FAST_N-1:0] = src_view[FAST_N-1:0];
    if (bus_addr == A_PEND_N) bus_rdata[NORM_N-1:0] = src_view[LOG_N-1:FAST_N];
    if (bus_addr == A_STAT_F && fast_valid) begin
      bus_rdata[DATA_W-1]   = 1'b1;
      bus_rdata[FIDX_W-1:0] = fast_idx;
    end
    if (bus_addr == A_STAT_N && norm_valid) begin
      bus_rdata[DATA_W-1]   = 1'b1;
      bus_rdata[NIDX_W-1:0] = norm_idx;
    end
  end
endmodule

// File: rtl/irq_map_ctrl_chk.sv
`timescale 1ns/1ps
module irq_map_ctrl_chk #(
  parameter int FAST_N = 4,
  parameter int NORM_N = 20,
  parameter int CTRL_W = 7,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int FIDX_W = 2,
  parameter int NIDX_W = 5
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 bus_wr,
  input logic [ADDR_W-1:0]                    bus_addr,
  input logic [DATA_W-1:0]                    bus_wdata,
  input logic [FAST_N+NORM_N-1:0][CTRL_W-1:0] ctrl_q,
  input logic [FAST_N+NORM_N-1:0]             edge_hit,
  input logic [FAST_N+NORM_N-1:0]             pend_q,
  input logic [FAST_N+NORM_N-1:0]             clr_strb,
  input logic [FAST_N+NORM_N-1:0]             src_act,
  input logic                                 fast_req_n,
  input logic                                 norm_req_n,
  input logic                                 fast_valid,
  input logic [FIDX_W-1:0]                    fast_idx,
  input logic                                 norm_valid,
  input logic [NIDX_W-1:0]                    norm_idx
);
  localparam int LOG_N = FAST_N + NORM_N;

  logic [FAST_N-1:0] act_f;
  logic [NORM_N-1:0] act_n;
  assign act_f = src_act[FAST_N-1:0];
  assign act_n = src_act[LOG_N-1:FAST_N];

  function automatic logic [NORM_N-1:0] below_mask(input int idx);
    logic [NORM_N-1:0] m;
    m = '0;
    for (int k = 0; k < NORM_N; k++)
      if (k < idx) m[k] = 1'b1;
    return m;
  endfunction

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (fast_req_n && norm_req_n));

  // R10
  fast_req_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_req_n == !(|act_f));

  // R10
  norm_req_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    norm_req_n == !(|act_n));

  // R11
  fast_stat_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_valid |-> act_f[fast_idx]);

  // R11
  norm_stat_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    norm_valid |-> (act_n[norm_idx] && ((act_n & below_mask(int'(norm_idx))) == '0)));

  for (genvar i = 0; i < LOG_N; i++) begin : g_src_chk
    // R2
    ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(i)) |=> ctrl_q[i] == $past(bus_wdata[CTRL_W-1:0]));

    // R6
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit[i] |=> pend_q[i]);

    // R6
    pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(edge_hit[i]));

    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_strb[i] && !edge_hit[i]) |=> !pend_q[i]);
  end
endmodule

bind irq_map_ctrl irq_map_ctrl_chk #(
  .FAST_N (FAST_N),
  .NORM_N (NORM_N),
  .CTRL_W (CTRL_W),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .FIDX_W (FIDX_W),
  .NIDX_W (NIDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .ctrl_q     (ctrl_q),
  .edge_hit   (edge_hit),
  .pend_q     (pend_q),
  .clr_strb   (clr_strb),
  .src_act    (src_act),
  .fast_req_n (fast_req_n),
  .norm_req_n (norm_req_n),
  .fast_valid (fast_valid),
  .fast_idx   (fast_idx),
  .norm_valid (norm_valid),
  .norm_idx   (norm_idx)
);

// File: tb/test_irq_map_ctrl.sv
`timescale 1ns/1ps
module test_irq_map_ctrl;
  localparam int PF = 32, PN = 33, SF = 34, SN = 35;
  localparam logic [31:0] VLD = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ext_irq = '0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fast_req_n, norm_req_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_map_ctrl i_irq_map_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fast_req_n(fast_req_n), .norm_req_n(norm_req_n));

  // reference model
  int          m_ctrl [24];
  bit          m_pend [24];
  logic [15:0] hist [$];

  function automatic bit m_view(input int i);
    int src;
    bit lvl;
    src = (m_ctrl[i] >> 3) & 15;
    lvl = hist[hist.size()-2][src];
    if ((m_ctrl[i] >> 1) & 1) return m_pend[i];
    return lvl ^ bit'((m_ctrl[i] >> 2) & 1);
  endfunction

  function automatic bit m_act(input int i);
    return m_view(i) && (m_ctrl[i] & 1);
  endfunction

  function automatic logic [31:0] m_status(input int lo, input int n);
    for (int j = 0; j < n; j++)
      if (m_act(lo + j)) return VLD | j;
    return 0;
  endfunction

  function automatic logic [31:0] m_read(input int a);
    logic [31:0] r;
    r = 0;
    if (a < 24) r = m_ctrl[a];
    else if (a == PF) for (int j = 0; j < 4; j++) r[j] = m_view(j);
    else if (a == PN) for (int j = 0; j < 20; j++) r[j] = m_view(4 + j);
    else if (a == SF) r = m_status(0, 4);
    else if (a == SN) r = m_status(4, 20);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 24; i++) begin m_ctrl[i] = 0; m_pend[i] = 0; end
      hist = '{16'h0, 16'h0, 16'h0};
    end else begin
      for (int i = 0; i < 24; i++) begin
        int  src;
        bit  cur, old, hit, clr;
        src = (m_ctrl[i] >> 3) & 15;
        cur = hist[hist.size()-2][src];
        old = hist[hist.size()-3][src];
        hit = ((m_ctrl[i] >> 2) & 1) ? (!cur && old) : (cur && !old);
        clr = bus_wr && ((i < 4) ? (bus_addr == PF && bus_wdata[i])
                                 : (bus_addr == PN && bus_wdata[i-4]));
        m_pend[i] = hit || (m_pend[i] && !clr);
      end
      if (bus_wr && bus_addr < 24) m_ctrl[bus_addr] = int'(bus_wdata & 32'h7F);
      hist.push_back(ext_irq);
      void'(hist.pop_front());
    end
    #2;
    if (rst_n && !done) begin
      bit af, an;
      af = 0; an = 0;
      for (int i = 0; i < 4; i++)  af |= m_act(i);
      for (int i = 4; i < 24; i++) an |= m_act(i);
      chk("R10 fast_req_n per cycle", fast_req_n, !af);
      chk("R10 norm_req_n per cycle", norm_req_n, !an);
      chk("R12 readout per cycle", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rchk(input int a, input logic [31:0] exp, input string tag);
    bus_addr = 6'(a);
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 fast_req_n", fast_req_n, 1);
    chk("R1 norm_req_n", norm_req_n, 1);
    rchk(0, 0, "R1 ctrl0");
    rchk(PF, 0, "R1 fast pending");
    rchk(PN, 0, "R1 normal pending");

    // R2 control readback, upper write bits dropped
    wr(0, 32'h19);
    rchk(0, 32'h19, "R2 ctrl0");
    wr(5, 32'hFFFF_FFFF);
    rchk(5, 32'h7F, "R2 ctrl5 masked");

    // R4 level active-high, two-edge delay
    @(negedge clk); ext_irq[3] = 1'b1;
    idle(1); rchk(PF, 0, "R4 level before sync");
    idle(1); rchk(PF, 1, "R4 level after sync");
    chk("R10 fast request", fast_req_n, 0);
    rchk(SF, VLD | 0, "R11 fast status");

    // R3 only the selected line matters
    @(negedge clk); ext_irq[3] = 1'b0; ext_irq[4] = 1'b1;
    idle(2); rchk(PF, 0, "R3 other line ignored");
    chk("R3 fast request idle", fast_req_n, 1);

    // R6 rising edge latches
    wr(5, 32'h3B);
    @(negedge clk); ext_irq[7] = 1'b1;
    idle(2); rchk(PN, 0, "R6 not yet latched");
    idle(1); rchk(PN, 32'h2, "R6 latched");
    @(negedge clk); ext_irq[7] = 1'b0;
    idle(3); rchk(PN, 32'h2, "R6 held after drop");
    rchk(SN, VLD | 1, "R11 normal status");

    // R7 active-low edge
    wr(9, 32'h3F);
    @(negedge clk); ext_irq[7] = 1'b1;
    idle(3); rchk(PN, 32'h2, "R7 rise ignored");
    @(negedge clk); ext_irq[7] = 1'b0;
    idle(3); rchk(PN, 32'h22, "R7 fall latched");
    rchk(SN, VLD | 1, "R11 lowest wins");

    // R8 clear behaviour
    wr(PN, 32'h2);
    rchk(PN, 32'h20, "R8 w1c clears");
    rchk(SN, VLD | 5, "R11 next lowest");
    wr(PN, 32'h0);
    rchk(PN, 32'h20, "R8 zero write no effect");
    @(negedge clk); ext_irq[3] = 1'b1;
    idle(2);
    wr(PF, 32'h1);
    rchk(PF, 32'h1, "R8 level bit not cleared");

    // R9 disabled source still records
    @(negedge clk); ext_irq[3] = 1'b0;
    wr(2, 32'h4A);
    idle(2);
    @(negedge clk); ext_irq[9] = 1'b1;
    idle(3);
    rchk(PF, 32'h4, "R9 pending while disabled");
    chk("R9 no request while disabled", fast_req_n, 1);
    rchk(SF, 0, "R9 no status while disabled");
    wr(2, 32'h4B);
    chk("R9 request once enabled", fast_req_n, 0);
    rchk(SF, VLD | 2, "R11 fast status idx2");

    // R5 level active-low
    wr(3, 32'h65);
    rchk(PF, 32'hC, "R5 low level active");
    @(negedge clk); ext_irq[12] = 1'b1;
    idle(2); rchk(PF, 32'h4, "R5 high level inactive");

    // R10 independence of groups
    wr(PN, 32'h20);
    chk("R10 normal released", norm_req_n, 1);
    chk("R10 fast unaffected", fast_req_n, 0);

    // R12 unmapped address
    rchk(40, 0, "R12 unmapped reads zero");
    rchk(24, 0, "R12 past last ctrl reads zero");

    idle(4);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule